// File: doc/BRIEF.md
# Overlay Window Shadow Register Bank

This block holds the per-window configuration for a set of display overlay windows. Each window has a buffer base address, whole-buffer width and height, read offsets into that buffer, a top-left and a bottom-right screen corner, two alpha levels, a pixel format code, an enable bit and, on every window except window 0, a colour-key value. Software writes all of these through a simple register port. Writes land in a shadow copy. The live copy, which drives the fetch and blend logic downstream, changes only on a vsync strobe.

A live update happens in three steps. Software sets the update request, which arms every window. At the next vsync, each armed window copies its shadow record into its live record and disarms. A window whose protect bit is set is skipped and stays armed. Its live record and its enable stay exactly as they were. At the first vsync after software clears that protect bit, the staged values go live.

The block also selects a fetch burst length for each window from the live padded buffer width. Reads of the register port return the staged shadow values, so software can check what it has written before it commits.

Top module: `win_shadow_bank`

## Requirements
- R1: Addresses are `{index[7:4], field[3:0]}`. Window fields are: 0 base address (bits 31:0), 1 whole width (bits 12:0), 2 whole height (bits 12:0), 3 x offset (bits 12:0), 4 y offset (bits 12:0), 5 top-left corner, 6 bottom-right corner, 7 alpha, 8 control, 9 colour key (bits 31:0). A write to a window field changes only its shadow. `rd_data_o` returns that shadow field with all other bits zero. No live output changes in a cycle without `vsync_i`.
- R2: Writing bit 0 = 1 to global field 1 (index 15) arms every window. A vsync with no window armed leaves every live record unchanged.
- R3: At a vsync, every window that is armed and unprotected copies its whole shadow record into its live record on that edge, then disarms. Reading global field 1 returns the armed bits, one per window, with window w at bit w.
- R4: Global field 0 (index 15) holds the protect bits, window w at bit w, and reads back as written. At a vsync, a protected window keeps its live record and stays armed. At the first vsync after its protect bit is cleared, its shadow goes live with no new request.
- R5: The control field has the enable at bit 0 and the format at bits 7:4. Clearing the enable in the shadow leaves the live enable at 1 until the committing vsync.
- R6: Window 0 has no colour key. Writes to its field 9 are ignored, and its read and live key stay 0. Other windows store the key.
- R7: `burst16_o[w]` is 1 (16-word bursts) when the live whole width of window w is 128 or more. Otherwise it is 0 (8-word bursts).
- R8: After reset, all shadow and live fields are 0, no window is armed or protected, and every `burst16_o` bit is 0.
- R9: The top-left and bottom-right fields carry x in bits 11:0 and y in bits 27:16. The alpha field carries alpha0 in bits 7:0 and alpha1 in bits 15:8. `live_cfg_o` holds window w at bits `[w*CFG_W +: CFG_W]`, in the layout of the package record `win_cfg_t`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address: index and field |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 32 | Shadow or global readback, combinational |
| vsync_i | input | 1 | Frame boundary strobe, one cycle |
| live_cfg_o | output | NUM_WIN*CFG_W | Live record of each window |
| burst16_o | output | NUM_WIN | 1 selects 16-word fetch bursts, 0 selects 8-word bursts |

## Verification
The bench sweeps every field of every window. It checks that the shadows read back correctly and that the live records stay untouched until a committed vsync. A design that copies on every write, or on every vsync, would fail there.

The bench holds one window protected across two vsyncs and then releases it without a new request. A design that dropped the armed state would never apply that window's staged values. A design that ignored the protect bit would apply them early.

The bench also checks three more cases. First, the live enable must stay high after it is cleared in the shadow, which catches a disable that bypasses the shadow. Second, writes to window 0's key must be ignored. Third, the burst selection is swept across widths of 126 to 129 and the extremes, which catches an off-by-one on the 128 threshold.

// File: rtl/win_regs_pkg.sv
package win_regs_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned BASE_W  = 32;
  localparam int unsigned DIM_W   = 13;
  localparam int unsigned COORD_W = 12;
  localparam int unsigned ALPHA_W = 8;
  localparam int unsigned FMT_W   = 4;
  localparam int unsigned KEY_W   = 32;
  localparam int unsigned FLD_W   = 4;
  localparam int unsigned Y_LSB   = 16;
  localparam int unsigned A1_LSB  = 8;
  localparam int unsigned FMT_LSB = 4;

  localparam logic [FLD_W-1:0] F_BASE    = 4'd0;
  localparam logic [FLD_W-1:0] F_WHOLE_W = 4'd1;
  localparam logic [FLD_W-1:0] F_WHOLE_H = 4'd2;
  localparam logic [FLD_W-1:0] F_OFF_X   = 4'd3;
  localparam logic [FLD_W-1:0] F_OFF_Y   = 4'd4;
  localparam logic [FLD_W-1:0] F_TL      = 4'd5;
  localparam logic [FLD_W-1:0] F_BR      = 4'd6;
  localparam logic [FLD_W-1:0] F_ALPHA   = 4'd7;
  localparam logic [FLD_W-1:0] F_CTRL    = 4'd8;
  localparam logic [FLD_W-1:0] F_KEY     = 4'd9;

  localparam logic [FLD_W-1:0] G_PROTECT = 4'd0;
  localparam logic [FLD_W-1:0] G_REQUEST = 4'd1;

  typedef struct packed {
    logic [BASE_W-1:0]  base;
    logic [DIM_W-1:0]   whole_w;
    logic [DIM_W-1:0]   whole_h;
    logic [DIM_W-1:0]   off_x;
    logic [DIM_W-1:0]   off_y;
    logic [COORD_W-1:0] tl_x;
    logic [COORD_W-1:0] tl_y;
    logic [COORD_W-1:0] br_x;
    logic [COORD_W-1:0] br_y;
    logic [ALPHA_W-1:0] alpha0;
    logic [ALPHA_W-1:0] alpha1;
    logic [FMT_W-1:0]   fmt;
    logic               en;
    logic [KEY_W-1:0]   key;
  } win_cfg_t;

  localparam int unsigned CFG_W = $bits(win_cfg_t);

  function automatic win_cfg_t fld_write(win_cfg_t c, logic [FLD_W-1:0] f,
                                         logic [REG_W-1:0] d, logic has_key);
    win_cfg_t r;
    r = c;
    case (f)
      F_BASE:    r.base    = d[BASE_W-1:0];
      F_WHOLE_W: r.whole_w = d[DIM_W-1:0];
      F_WHOLE_H: r.whole_h = d[DIM_W-1:0];
      F_OFF_X:   r.off_x   = d[DIM_W-1:0];
      F_OFF_Y:   r.off_y   = d[DIM_W-1:0];
      F_TL: begin
        r.tl_x = d[COORD_W-1:0];
        r.tl_y = d[Y_LSB +: COORD_W];
      end
      F_BR: begin
        r.br_x = d[COORD_W-1:0];
        r.br_y = d[Y_LSB +: COORD_W];
      end
      F_ALPHA: begin
        r.alpha0 = d[ALPHA_W-1:0];
        r.alpha1 = d[A1_LSB +: ALPHA_W];
      end
      F_CTRL: begin
        r.en  = d[0];
        r.fmt = d[FMT_LSB +: FMT_W];
      end
      F_KEY: if (has_key) r.key = d[KEY_W-1:0];
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic [REG_W-1:0] fld_read(win_cfg_t c, logic [FLD_W-1:0] f);
    logic [REG_W-1:0] r;
    r = '0;
    case (f)
      F_BASE:    r[BASE_W-1:0] = c.base;
      F_WHOLE_W: r[DIM_W-1:0]  = c.whole_w;
      F_WHOLE_H: r[DIM_W-1:0]  = c.whole_h;
      F_OFF_X:   r[DIM_W-1:0]  = c.off_x;
      F_OFF_Y:   r[DIM_W-1:0]  = c.off_y;
      F_TL: begin
        r[COORD_W-1:0]      = c.tl_x;
        r[Y_LSB +: COORD_W] = c.tl_y;
      end
      F_BR: begin
        r[COORD_W-1:0]      = c.br_x;
        r[Y_LSB +: COORD_W] = c.br_y;
      end
      F_ALPHA: begin
        r[ALPHA_W-1:0]       = c.alpha0;
        r[A1_LSB +: ALPHA_W] = c.alpha1;
      end
      F_CTRL: begin
        r[0]                = c.en;
        r[FMT_LSB +: FMT_W] = c.fmt;
      end
      F_KEY:   r[KEY_W-1:0] = c.key;
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/win_slot.sv
module win_slot
  import win_regs_pkg::*;
#(
  parameter int unsigned IDX = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [FLD_W-1:0] fld_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             arm_i,
  input  logic             vsync_i,
  input  logic             protect_i,
  output win_cfg_t         shadow_o,
  output win_cfg_t         live_o,
  output logic             pending_o
);
  localparam logic HAS_KEY = (IDX != 0);

  win_cfg_t shadow_q, live_q;
  logic     pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else if (wr_en_i) shadow_q <= fld_write(shadow_q, fld_i, wr_data_i, HAS_KEY);
  end

  // Live copy moves only at vsync, only when armed and not held back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= '0;
    else if (vsync_i && pend_q && !protect_i) live_q <= shadow_q;
  end

  // A new request wins over a disarm in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else if (arm_i) pend_q <= 1'b1;
    else if (vsync_i && !protect_i) pend_q <= 1'b0;
  end

  assign shadow_o  = shadow_q;
  assign live_o    = live_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/win_burst_sel.sv
module win_burst_sel #(
  parameter int unsigned WIDTH_W = 13,
  parameter int unsigned MIN_W   = 128
) (
  input  logic [WIDTH_W-1:0] whole_w_i,
  output logic               burst16_o
);
  localparam logic [WIDTH_W-1:0] MIN_V = WIDTH_W'(MIN_W);
  assign burst16_o = (whole_w_i >= MIN_V);
endmodule

// File: rtl/win_shadow_bank.sv
module win_shadow_bank
  import win_regs_pkg::*;
#(
  parameter int unsigned NUM_WIN     = 3,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BURST_MIN_W = 128
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [REG_W-1:0]         wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [REG_W-1:0]         rd_data_o,
  input  logic                     vsync_i,
  output logic [NUM_WIN*CFG_W-1:0] live_cfg_o,
  output logic [NUM_WIN-1:0]       burst16_o
);
  localparam int unsigned IDX_W = ADDR_W - FLD_W;
  localparam logic [IDX_W-1:0] GLB_IDX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [FLD_W-1:0] wr_fld, rd_fld;
  logic             glb_wr, arm;
  logic [NUM_WIN-1:0] protect_q, pend_q;
  win_cfg_t shadow_q [NUM_WIN];
  win_cfg_t live_q   [NUM_WIN];
  logic [NUM_WIN*CFG_W-1:0] shadow_flat;

  assign wr_idx = wr_addr_i[ADDR_W-1:FLD_W];
  assign wr_fld = wr_addr_i[FLD_W-1:0];
  assign rd_idx = rd_addr_i[ADDR_W-1:FLD_W];
  assign rd_fld = rd_addr_i[FLD_W-1:0];
  assign glb_wr = wr_en_i && (wr_idx == GLB_IDX);
  assign arm    = glb_wr && (wr_fld == G_REQUEST) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) protect_q <= '0;
    else if (glb_wr && wr_fld == G_PROTECT) protect_q <= wr_data_i[NUM_WIN-1:0];
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic win_wr;
    assign win_wr = wr_en_i && (wr_idx == IDX_W'(w));

    win_slot #(.IDX(w)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (win_wr),
      .fld_i     (wr_fld),
      .wr_data_i (wr_data_i),
      .arm_i     (arm),
      .vsync_i   (vsync_i),
      .protect_i (protect_q[w]),
      .shadow_o  (shadow_q[w]),
      .live_o    (live_q[w]),
      .pending_o (pend_q[w])
    );

    win_burst_sel #(.WIDTH_W(DIM_W), .MIN_W(BURST_MIN_W)) u_burst (
      .whole_w_i (live_q[w].whole_w),
      .burst16_o (burst16_o[w])
    );

    assign live_cfg_o[w*CFG_W +: CFG_W]  = live_q[w];
    assign shadow_flat[w*CFG_W +: CFG_W] = shadow_q[w];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_idx == GLB_IDX) begin
      if (rd_fld == G_PROTECT)      rd_data_o[NUM_WIN-1:0] = protect_q;
      else if (rd_fld == G_REQUEST) rd_data_o[NUM_WIN-1:0] = pend_q;
    end else begin
      for (int w = 0; w < NUM_WIN; w++)
        if (rd_idx == IDX_W'(w)) rd_data_o = fld_read(shadow_q[w], rd_fld);
    end
  end
endmodule

// File: rtl/win_shadow_bank_chk.sv
module win_shadow_bank_chk
  import win_regs_pkg::*;
#(
  parameter int unsigned NUM_WIN = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     vsync_i,
  input logic [NUM_WIN-1:0]       protect_i,
  input logic [NUM_WIN-1:0]       pending_i,
  input logic [NUM_WIN*CFG_W-1:0] shadow_i,
  input logic [NUM_WIN*CFG_W-1:0] live_i,
  input logic [NUM_WIN-1:0]       burst16_i
);
  win_cfg_t live0;
  assign live0 = win_cfg_t'(live_i[CFG_W-1:0]);

  // R1: live records move only on a vsync edge
  p_live_needs_vsync_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> $stable(live_i));

  // R7: burst selection follows live width, so it is also frozen between vsyncs
  p_burst_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_i |=> $stable(burst16_i));

  // R6: window 0 never carries a live key
  p_no_key_win0_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live0.key == '0);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    p_hold_protected_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vsync_i && protect_i[w] |=> $stable(live_i[w*CFG_W +: CFG_W]));

    p_keep_armed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vsync_i && protect_i[w] && pending_i[w] |=> pending_i[w]);

    p_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vsync_i && pending_i[w] && !protect_i[w]
      |=> live_i[w*CFG_W +: CFG_W] == $past(shadow_i[w*CFG_W +: CFG_W]));

    p_idle_vsync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vsync_i && !pending_i[w] |=> $stable(live_i[w*CFG_W +: CFG_W]));
  end
endmodule

bind win_shadow_bank win_shadow_bank_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vsync_i   (vsync_i),
  .protect_i (protect_q),
  .pending_i (pend_q),
  .shadow_i  (shadow_flat),
  .live_i    (live_cfg_o),
  .burst16_i (burst16_o)
);

// File: tb/win_shadow_bank_tb.sv
module win_shadow_bank_tb;
  import win_regs_pkg::*;

  localparam int unsigned NW = 3;
  localparam int unsigned AW = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, vsync_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [31:0] wr_data_i = '0, rd_data_o;
  logic [NW*CFG_W-1:0] live_cfg_o;
  logic [NW-1:0] burst16_o;

  always #2 clk = ~clk;

  win_shadow_bank #(.NUM_WIN(NW), .ADDR_W(AW), .BURST_MIN_W(128)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .vsync_i(vsync_i), .live_cfg_o(live_cfg_o), .burst16_o(burst16_o));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  win_cfg_t exp_sh [NW];
  win_cfg_t exp_lv [NW];
  logic [NW-1:0] exp_pend = '0, exp_prot = '0;

  function automatic logic [31:0] exp_read(win_cfg_t c, int f);
    logic [31:0] r = '0;
    case (f)
      0: r = c.base;
      1: r[12:0] = c.whole_w;
      2: r[12:0] = c.whole_h;
      3: r[12:0] = c.off_x;
      4: r[12:0] = c.off_y;
      5: begin r[11:0] = c.tl_x; r[27:16] = c.tl_y; end
      6: begin r[11:0] = c.br_x; r[27:16] = c.br_y; end
      7: begin r[7:0] = c.alpha0; r[15:8] = c.alpha1; end
      8: begin r[0] = c.en; r[7:4] = c.fmt; end
      9: r = c.key;
      default: ;
    endcase
    return r;
  endfunction

  task automatic chk32(logic [31:0] act, logic [31:0] exp, string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_live(int w, string tag);
    win_cfg_t act;
    act = win_cfg_t'(live_cfg_o[w*CFG_W +: CFG_W]);
    n_cmp++;
    if (act !== exp_lv[w]) begin
      n_bad++;
      $display("FAIL %s win%0d act=%h exp=%h", tag, w, act, exp_lv[w]);
    end
    chk32({31'd0, burst16_o[w]}, {31'd0, exp_lv[w].whole_w >= 13'd128}, "R7 burst");
  endtask

  task automatic rd(int idx, int f, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_addr_i = AW'((idx << 4) | f);
    #1 chk32(rd_data_o, exp, tag);
  endtask

  task automatic wr_raw(int idx, int f, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = AW'((idx << 4) | f); wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wr_fld(int w, int f, logic [31:0] d);
    wr_raw(w, f, d);
    case (f)
      0: exp_sh[w].base = d;
      1: exp_sh[w].whole_w = d[12:0];
      2: exp_sh[w].whole_h = d[12:0];
      3: exp_sh[w].off_x = d[12:0];
      4: exp_sh[w].off_y = d[12:0];
      5: begin exp_sh[w].tl_x = d[11:0]; exp_sh[w].tl_y = d[27:16]; end
      6: begin exp_sh[w].br_x = d[11:0]; exp_sh[w].br_y = d[27:16]; end
      7: begin exp_sh[w].alpha0 = d[7:0]; exp_sh[w].alpha1 = d[15:8]; end
      8: begin exp_sh[w].en = d[0]; exp_sh[w].fmt = d[7:4]; end
      9: if (w != 0) exp_sh[w].key = d;
      default: ;
    endcase
  endtask

  task automatic set_prot(logic [NW-1:0] p);
    wr_raw(15, 0, {29'd0, p});
    exp_prot = p;
  endtask

  task automatic arm();
    wr_raw(15, 1, 32'd1);
    exp_pend = '1;
  endtask

  task automatic vsync();
    @(negedge clk);
    vsync_i = 1'b1;
    @(negedge clk);
    vsync_i = 1'b0;
    for (int w = 0; w < NW; w++)
      if (exp_pend[w] && !exp_prot[w]) begin
        exp_lv[w] = exp_sh[w];
        exp_pend[w] = 1'b0;
      end
  endtask

  task automatic all_live(string tag);
    for (int w = 0; w < NW; w++) chk_live(w, tag);
  endtask

  initial begin
    for (int w = 0; w < NW; w++) begin exp_sh[w] = '0; exp_lv[w] = '0; end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R8: reset state
    all_live("R8 reset live");
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < 10; f++) rd(w, f, 32'd0, "R8 reset shadow");
    rd(15, 0, 32'd0, "R8 reset protect");
    rd(15, 1, 32'd0, "R8 reset armed");

    // R1/R9/R6: full field sweep, shadows only
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < 10; f++)
        wr_fld(w, f, 32'h9E3779B9 * (w * 16 + f + 1));
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < 10; f++) rd(w, f, exp_read(exp_sh[w], f), "R1 R9 shadow readback");
    rd(0, 9, 32'd0, "R6 win0 key reads zero");
    all_live("R1 live untouched by writes");

    // R2: vsync without request
    vsync();
    all_live("R2 unarmed vsync");

    // R3/R4: protect window 2, commit the others
    set_prot(3'b100);
    rd(15, 0, 32'd4, "R4 protect readback");
    arm();
    rd(15, 1, 32'd7, "R3 armed readback");
    vsync();
    all_live("R3 R4 partial commit");
    rd(15, 1, 32'd4, "R4 protected stays armed");
    wr_fld(2, 0, 32'hCAFE0123);
    vsync();
    all_live("R4 held over second vsync");
    set_prot(3'b000);
    chk_live(2, "R4 unprotect alone does not commit");
    vsync();
    all_live("R4 commit after release");
    rd(15, 1, 32'd0, "R3 disarmed");

    // R5: disable lands only at vsync
    wr_fld(1, 8, 32'h0000_0051);
    arm(); vsync();
    chk32({31'd0, exp_lv[1].en}, 32'd1, "R5 enabled");
    chk_live(1, "R5 enabled live");
    wr_fld(1, 8, 32'h0000_0050);
    repeat (4) @(negedge clk);
    chk_live(1, "R5 enable still live before vsync");
    arm();
    chk_live(1, "R5 enable still live while armed");
    vsync();
    chk_live(1, "R5 disabled after vsync");
    chk32({31'd0, exp_lv[1].en}, 32'd0, "R5 model disabled");

    // R6: key on window 0 ignored, window 1 stored
    wr_fld(0, 9, 32'h12345678);
    wr_fld(1, 9, 32'h89ABCDEF);
    rd(0, 9, 32'd0, "R6 win0 key ignored");
    rd(1, 9, 32'h89ABCDEF, "R6 win1 key stored");
    arm(); vsync();
    all_live("R6 key commit");

    // R7: burst threshold sweep on window 1
    foreach (exp_sh[i]) ;
    begin
      int widths[10] = '{0, 1, 64, 126, 127, 128, 129, 255, 4000, 8191};
      for (int i = 0; i < 10; i++) begin
        wr_fld(1, 1, widths[i]);
        arm(); vsync();
        all_live("R7 burst sweep");
        chk32({31'd0, burst16_o[1]}, {31'd0, widths[i] >= 128}, "R7 threshold");
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired (all requirements) act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule